// File: doc/BRIEF.md
# Interrupt Handler Entry-Point Fetch Engine

This block turns an interrupt vector number into the entry point of its handler. Given an 8-bit vector and a table-mode select, it reads the handler's table entry one byte at a time over a byte-wide memory port and assembles the result little-endian. It then presents the result with a one-cycle completion strobe. Mode 0 walks a fixed table of 4-byte entries that starts at address zero. Mode 1 walks a table of 8-byte descriptors that can sit anywhere, at a base given on an input.

In mode 0 the result is a 16-bit segment, a 16-bit offset and a 20-bit physical address, equal to the segment times sixteen plus the offset. In mode 1 the result is a 32-bit offset, a 16-bit selector and an attribute byte.

The engine is a four-state machine:
- `ST_IDLE` waits for `start`. A start moves it to `ST_ISSUE` and latches the vector, the mode and the base.
- `ST_ISSUE` drives a one-cycle read request and always moves to `ST_AWAIT`.
- `ST_AWAIT` holds until `mem_vld`. It then stores the byte and moves to `ST_ISSUE` if more bytes remain, or to `ST_DONE` after the last byte.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `ivec_fetch`

## Requirements
- R1: After reset, `done` and `mem_req` are both 0 until a start is accepted.
- R2: In mode 0 (`prot_mode`=0) the engine issues exactly 4 reads, at addresses vector*4, vector*4+1, vector*4+2 and vector*4+3, in that order. Every mode-0 read address lies below 400h.
- R3: In mode 0, entry byte 0 is offset bits 7:0 and byte 1 is offset bits 15:8. Byte 2 is segment bits 7:0 and byte 3 is segment bits 15:8. The segment appears on `res_seg` and the offset on `res_off[15:0]`.
- R4: In mode 0, `res_phys` equals segment*16 + offset modulo 2^20. For example, entry bytes 2A,33,3C,4A give segment 4A3Ch, offset 332Ah and address 4D6EAh.
- R5: In mode 1 (`prot_mode`=1) the engine issues exactly 8 reads at ascending addresses. They start at `tbl_base` + vector*8, computed modulo 2^32.
- R6: In mode 1, `res_off` is {byte7, byte6, byte1, byte0}, `res_seg` (the selector) is {byte3, byte2} and `res_attr` is byte 5. Byte 4 has no effect on any output.
- R7: At most one read is outstanding: `mem_req` is a one-cycle pulse, and the next request is issued only after `mem_vld` returns the previous byte. Any memory latency of one or more cycles works.
- R8: `done` is high for exactly one cycle per fetch. The result outputs stay at the fetched values after `done` until the next fetch begins.
- R9: A `start` seen while a fetch is in progress, including the `done` cycle, is ignored. It does not change the vector, mode, read sequence or result of the running fetch.
- R10: In mode 0, `res_off[31:16]` and `res_attr` are 0. In mode 1, `res_phys` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| prot_mode | input | 1 | Table mode: 0 = fixed 4-byte table at 0, 1 = relocatable 8-byte descriptors |
| vec_num | input | VEC_W | Interrupt vector number |
| tbl_base | input | ADDR_W | Descriptor table base (mode 1 only) |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_vld | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion strobe |
| res_seg | output | 16 | Segment (mode 0) or selector (mode 1) |
| res_off | output | 32 | Handler offset |
| res_phys | output | PHYS_W | Physical address (mode 0), else 0 |
| res_attr | output | 8 | Attribute byte (mode 1), else 0 |

## Verification
The bench builds the engine with its defaults: an 8-bit vector, a 32-bit address and a 20-bit physical address. With these values the last mode-0 entry ends exactly at 3FFh. A base of FFFFFFF0h makes the descriptor address wrap through 2^32, and an entry of segment FFFFh with offset FFF0h carries the physical sum out of 20 bits. The bench memory model varies its read latency from one to four cycles per fetch, which exercises the single-outstanding handshake at several spacings.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int RM_BYTES = 4;
    localparam int PM_BYTES = 8;
    localparam int RM_SHIFT = $clog2(RM_BYTES);
    localparam int PM_SHIFT = $clog2(PM_BYTES);
    localparam int IDX_W    = $clog2(PM_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2,
        ST_DONE  = 2'd3
    } fetch_st_t;
endpackage

// File: rtl/ivec_entry_addr.sv
module ivec_entry_addr
    import ivec_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              prot,
    input  logic [VEC_W-1:0]  vec,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] entry_o
);
    logic [ADDR_W-1:0] rm_entry;
    logic [ADDR_W-1:0] pm_entry;

    assign rm_entry = ADDR_W'({vec, {RM_SHIFT{1'b0}}});
    assign pm_entry = base + ADDR_W'({vec, {PM_SHIFT{1'b0}}});
    assign entry_o  = prot ? pm_entry : rm_entry;
endmodule

// File: rtl/ivec_byte_store.sv
module ivec_byte_store #(
    parameter int NB = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NB)-1:0]  wr_idx,
    input  logic [7:0]             wr_data,
    output logic [NB-1:0][7:0]     bytes_o
);
    localparam int IW = $clog2(NB);

    logic [7:0] slot_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
        assign bytes_o[g] = slot_q[g];
    end
endmodule

// File: rtl/ivec_result_form.sv
module ivec_result_form
    import ivec_pkg::*;
#(
    parameter int PHYS_W = 20
) (
    input  logic                     prot,
    input  logic [PM_BYTES-1:0][7:0] ent,
    output logic [15:0]              seg_o,
    output logic [31:0]              off_o,
    output logic [PHYS_W-1:0]        phys_o,
    output logic [7:0]               attr_o
);
    logic [15:0] low_off;

    assign low_off = {ent[1], ent[0]};
    assign seg_o   = {ent[3], ent[2]};

    always_comb begin
        if (prot) begin
            off_o  = {ent[7], ent[6], low_off};
            attr_o = ent[5];
            phys_o = '0;
        end else begin
            off_o  = {16'h0000, low_off};
            attr_o = 8'h00;
            phys_o = PHYS_W'({seg_o, 4'h0}) + PHYS_W'(low_off);
        end
    end
endmodule

// File: rtl/ivec_fetch.sv
module ivec_fetch
    import ivec_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int PHYS_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prot_mode,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_vld,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic [15:0]       res_seg,
    output logic [31:0]       res_off,
    output logic [PHYS_W-1:0] res_phys,
    output logic [7:0]        res_attr
);
    localparam logic [ADDR_W-1:0] RM_LIMIT = ADDR_W'(RM_BYTES) << VEC_W;

    fetch_st_t               st_q, st_d;
    logic [VEC_W-1:0]        vec_q;
    logic [ADDR_W-1:0]       base_q;
    logic                    prot_q;
    logic [IDX_W-1:0]        idx_q;
    logic [IDX_W-1:0]        last_idx;
    logic [ADDR_W-1:0]       entry_addr;
    logic                    wr_en;
    logic [PM_BYTES-1:0][7:0] ent_bytes;

    assign last_idx = prot_q ? IDX_W'(PM_BYTES - 1) : IDX_W'(RM_BYTES - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d    = st_q;
        mem_req = 1'b0;
        done    = 1'b0;
        wr_en   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                mem_req = 1'b1;
                st_d    = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (mem_vld) begin
                    wr_en = 1'b1;
                    st_d  = (idx_q == last_idx) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Request context and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            base_q <= '0;
            prot_q <= 1'b0;
            idx_q  <= '0;
        end else if (st_q == ST_IDLE && start) begin
            vec_q  <= vec_num;
            base_q <= tbl_base;
            prot_q <= prot_mode;
            idx_q  <= '0;
        end else if (wr_en) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    ivec_entry_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_addr (
        .prot    (prot_q),
        .vec     (vec_q),
        .base    (base_q),
        .entry_o (entry_addr)
    );

    assign mem_addr = entry_addr + ADDR_W'(idx_q);

    ivec_byte_store #(.NB(PM_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (mem_rdata),
        .bytes_o (ent_bytes)
    );

    ivec_result_form #(.PHYS_W(PHYS_W)) u_form (
        .prot   (prot_q),
        .ent    (ent_bytes),
        .seg_o  (res_seg),
        .off_o  (res_off),
        .phys_o (res_phys),
        .attr_o (res_attr)
    );

    // Checker state: address of the previous request in this fetch
    logic [ADDR_W-1:0] chk_prev;
    logic              chk_have;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_prev <= '0;
            chk_have <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            chk_have <= 1'b0;
        end else if (mem_req) begin
            chk_prev <= mem_addr;
            chk_have <= 1'b1;
        end
    end

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_real_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !prot_q) |-> (mem_addr < RM_LIMIT));

    // R2 and R5: byte reads climb by one within a fetch
    assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && chk_have) |-> (mem_addr == chk_prev + 1'b1));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && start) |=> ($stable(vec_q) && $stable(prot_q) && $stable(base_q)));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!mem_req && !done));
endmodule

// File: tb/sim_ivec_fetch.sv
`timescale 1ns/1ps
module sim_ivec_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prot_mode = 1'b0;
    logic [7:0]  vec_num = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_vld = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] res_seg;
    logic [31:0] res_off;
    logic [19:0] res_phys;
    logic [7:0]  res_attr;

    always #2.5 clk = ~clk;

    ivec_fetch u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .prot_mode(prot_mode),
        .vec_num(vec_num), .tbl_base(tbl_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_vld(mem_vld), .mem_rdata(mem_rdata),
        .done(done), .res_seg(res_seg), .res_off(res_off),
        .res_phys(res_phys), .res_attr(res_attr)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        case (a)
            32'h108: return 8'h2A;
            32'h109: return 8'h33;
            32'h10A: return 8'h3C;
            32'h10B: return 8'h4A;
            32'h040: return 8'hF0;
            32'h041, 32'h042, 32'h043: return 8'hFF;
            default: return (a[7:0] * 8'd29) ^ a[15:8] ^ a[31:24] ^ 8'hA5;
        endcase
    endfunction

    // Memory model with variable latency
    int          mem_lat = 1;
    int          lat_cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    always @(posedge clk) begin
        mem_vld <= 1'b0;
        if (mem_req) begin
            pend      <= 1'b1;
            pend_addr <= mem_addr;
            lat_cnt   <= mem_lat;
        end else if (pend) begin
            if (lat_cnt <= 1) begin
                mem_vld   <= 1'b1;
                mem_rdata <= mem_byte(pend_addr);
                pend      <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    // Request monitor
    logic        clr_mon = 1'b0;
    int          req_n = 0;
    int          ovl = 0;
    logic [31:0] req_a [8];
    always @(posedge clk) begin
        if (clr_mon) begin
            req_n <= 0;
            ovl   <= 0;
        end else if (mem_req) begin
            if (req_n < 8) req_a[req_n] <= mem_addr;
            req_n <= req_n + 1;
            if (pend) ovl <= ovl + 1;
        end
    end

    localparam int NV = 7;
    localparam logic        TV_PM   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [7:0]  TV_VEC  [NV] = '{8'h42, 8'h00, 8'hFF, 8'h10, 8'h42, 8'h03, 8'hFF};
    localparam logic [31:0] TV_BASE [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                             32'h0001_0000, 32'hFFFF_FFF0, 32'h0000_2000};
    localparam int          TV_LAT  [NV] = '{1, 3, 2, 1, 2, 1, 4};

    task automatic run_fetch(input logic pm, input logic [7:0] v, input logic [31:0] b,
                             input int lat, input bit disturb);
        logic [31:0] ea;
        logic [7:0]  eb [8];
        logic [15:0] e_seg;
        logic [31:0] e_off;
        logic [19:0] e_phys;
        logic [7:0]  e_attr;
        int nb;
        int cyc;
        mem_lat = lat;
        ea = pm ? (b + {21'h0, v, 3'b000}) : {22'h0, v, 2'b00};
        nb = pm ? 8 : 4;
        for (int i = 0; i < 8; i++) eb[i] = mem_byte(ea + i);
        e_seg = {eb[3], eb[2]};
        if (pm) begin
            e_off  = {eb[7], eb[6], eb[1], eb[0]};
            e_attr = eb[5];
            e_phys = '0;
        end else begin
            e_off  = {16'h0, eb[1], eb[0]};
            e_attr = 8'h00;
            e_phys = {e_seg, 4'h0} + {4'h0, eb[1], eb[0]};
        end

        @(negedge clk);
        clr_mon = 1'b1; prot_mode = pm; vec_num = v; tbl_base = b; start = 1'b1;
        @(negedge clk);
        clr_mon = 1'b0; start = 1'b0;
        if (disturb) begin
            prot_mode = ~pm; vec_num = v + 8'd1; tbl_base = b + 32'd64; start = 1'b1;
            repeat (6) @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8", "done seen before timeout", {63'h0, done}, 64'h1);

        chk(pm ? "R5" : "R2", "read count", 64'(req_n), 64'(nb));
        for (int i = 0; i < nb; i++)
            chk(pm ? "R5" : "R2", "read address", {32'h0, req_a[i]}, {32'h0, ea + i});
        chk("R7", "overlapped requests", 64'(ovl), 64'h0);
        chk(pm ? "R6" : "R3", "segment/selector", {48'h0, res_seg}, {48'h0, e_seg});
        chk(pm ? "R6" : "R3", "offset", {32'h0, res_off}, {32'h0, e_off});
        if (pm) begin
            chk("R6", "attribute byte", {56'h0, res_attr}, {56'h0, e_attr});
            chk("R10", "phys zero in mode 1", {44'h0, res_phys}, 64'h0);
        end else begin
            chk("R4", "physical address", {44'h0, res_phys}, {44'h0, e_phys});
            chk("R10", "attr and high offset zero", {24'h0, res_attr, res_off[31:16]}, 64'h0);
        end
        if (disturb) chk("R9", "vector of running fetch kept", {32'h0, req_a[0]}, {32'h0, ea});

        @(negedge clk);
        chk("R8", "done low after one cycle", {63'h0, done}, 64'h0);
        chk("R8", "results held after done", {res_seg, res_off, 16'h0},
            {e_seg, e_off, 16'h0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", {63'h0, done}, 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "done after reset", {63'h0, done}, 64'h0);
        chk("R1", "mem_req after reset", {63'h0, mem_req}, 64'h0);

        for (int k = 0; k < NV; k++)
            run_fetch(TV_PM[k], TV_VEC[k], TV_BASE[k], TV_LAT[k], 1'b0);

        // R4: worked example, vector 42h
        run_fetch(1'b0, 8'h42, 32'h0, 2, 1'b0);
        chk("R4", "example segment", {48'h0, res_seg}, 64'h4A3C);
        chk("R4", "example offset", {32'h0, res_off}, 64'h332A);
        chk("R4", "example physical", {44'h0, res_phys}, 64'h4D6EA);

        // R4: carry out of 20 bits wraps (FFFF:FFF0 -> 0FFE0)
        run_fetch(1'b0, 8'h10, 32'h0, 1, 1'b0);
        chk("R4", "physical wrap", {44'h0, res_phys}, 64'h0FFE0);

        // R5: base wraps through 2^32 (FFFFFFF0 + 3*8 = 8)
        run_fetch(1'b1, 8'h03, 32'hFFFF_FFF0, 1, 1'b0);
        chk("R5", "wrapped first address", {32'h0, req_a[0]}, 64'h8);

        // R9: start held high during a fetch in each mode
        run_fetch(1'b0, 8'h42, 32'h0, 1, 1'b1);
        run_fetch(1'b1, 8'h20, 32'h0000_4000, 1, 1'b1);

        // R6: byte 4 of the descriptor has no effect on the outputs
        run_fetch(1'b1, 8'h00, 32'h0000_0100, 1, 1'b0);
        chk("R6", "byte 4 unused", {res_seg, res_attr, 40'h0},
            {mem_byte(32'h103), mem_byte(32'h102), mem_byte(32'h105), 40'h0});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule